// File: doc/BRIEF.md
# Decoupled Instruction Fetch and Execute Pipeline

This block is a cycle-level model of how instructions move through a processor core that has two coupled pipelines. A four-stage front end computes fetch addresses, spends two cycles on each fetch, and then early-decodes the instruction. An eight-entry instruction queue sits between the front end and a two-stage back end. The back end has one stage for decode and operand fetch, and one stage for memory access and execution whose length depends on the instruction. The real instruction set, the caches and branch prediction are outside the model. Its purpose is to reproduce, cycle by cycle, when each instruction leaves the pipeline.

The fetch address generator is steered by a two-bit command: run, hold, jump to a target, or halt. Both pipelines share one memory bus. The execute stage wins the bus whenever it needs it, and memory can refuse every transfer by lowering a ready line. When a fetch is accepted, memory returns the instruction word in the same cycle, together with a latency tag that sets how long that instruction stays in the execute stage. Each instruction leaving the execute stage is reported with its address and its word.

Top module: `fetch_exec_core`

## Requirements
- R1: While reset is high, and after it is released, the block is halted. It raises no bus request and reports no retirement until a jump command arrives.
- R2: The command input is encoded as 0 run, 1 hold, 2 jump, 3 halt. Under run with room in the first fetch stage, the block fetches the current address. After each accepted fetch the address advances by 4, so the fetch addresses after a jump rise in steps of 4.
- R3: A jump to target T issues no fetch in its own cycle, and the next address fetched is T+4. At the end of the jump cycle the three fetch stages and the queue are emptied. Instructions already in decode or execute still retire, and only instructions fetched after the jump follow them.
- R4: While hold is applied, no fetch request is raised and the address is kept. Once run resumes, fetching continues at the first address not yet fetched.
- R5: After halt, no fetch is issued until the next jump. Every instruction already accepted retires, and the block then reports no further retirements.
- R6: An instruction fetched in cycle c with latency tag 0 is reported as retired in cycle c+7, provided nothing ahead of it stalls.
- R7: The queue holds 8 instructions. When the execute stage is blocked, the front end stops once 13 instructions are in flight: one in execute, one in decode, 8 in the queue and 3 in the fetch stages.
- R8: An instruction whose latency tag is k stays in the execute stage for k+1 cycles. The tag is sampled from mem_rlat_i together with the instruction word, so back-to-back tag-0 instructions retire one per cycle.
- R9: An instruction word whose top bit is 1 needs data memory. In its first execute cycle it requests the bus at the address formed by the lower word bits, zero-extended. This request takes priority over fetch, and the instruction cannot finish before the bus accepts it.
- R10: While mem_ready_i is low, the bus accepts nothing. Pending requests stay raised, and no fetch address is skipped.
- R11: Instructions retire in fetch order, and each one is reported with the address it was fetched from and the word memory returned for that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Address generator command: 0 run, 1 hold, 2 jump, 3 halt |
| tgt_i | input | 16 | Jump target; the first fetch after the jump is target+4 |
| mem_req_o | output | 1 | Bus request from the winning requester |
| mem_src_o | output | 1 | Requester on the bus: 0 fetch, 1 execute |
| mem_addr_o | output | 16 | Bus address |
| mem_ready_i | input | 1 | Memory accepts the current request |
| mem_rdata_i | input | 16 | Instruction word returned for an accepted fetch |
| mem_rlat_i | input | 5 | Execute latency tag returned with that word |
| ret_valid_o | output | 1 | One instruction left the execute stage |
| ret_addr_o | output | 16 | Fetch address of the retired instruction |
| ret_word_o | output | 16 | Word of the retired instruction |

## Verification
The bench builds the block with the default queue depth of 8, three fetch stages after address generation, and a 5-bit latency tag. The 5-bit tag allows a single instruction to occupy the execute stage for 32 cycles. That is long enough for all 13 in-flight slots to fill and settle, and for a jump to flush a completely full front end while decode and execute are still occupied. With 16-bit addresses, the memory model can map each address to a distinct word, so every retirement can be checked against its fetch address. Single addresses are given the long latency tag or the data-access flag, which shows the exact cycle at which execute takes the bus ahead of fetch.

// File: rtl/fxp_pkg.sv
`timescale 1ns/1ps
package fxp_pkg;
    localparam int unsigned AW = 16;
    localparam int unsigned DW = 16;
    localparam int unsigned LW = 5;
    localparam logic [AW-1:0] STEP = AW'(4);

    typedef enum logic [1:0] {
        CMD_RUN  = 2'd0,
        CMD_HOLD = 2'd1,
        CMD_JUMP = 2'd2,
        CMD_HALT = 2'd3
    } ag_cmd_e;

    typedef enum logic {
        SRC_FETCH = 1'b0,
        SRC_EXEC  = 1'b1
    } bus_src_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] word;
        logic [LW-1:0] lat;
    } islot_t;

    function automatic logic needs_mem(input logic [DW-1:0] w);
        return w[DW-1];
    endfunction

    function automatic logic [AW-1:0] data_addr(input logic [DW-1:0] w);
        return AW'(w[DW-2:0]);
    endfunction
endpackage

// File: rtl/fxp_addr_gen.sv
`timescale 1ns/1ps
module fxp_addr_gen
    import fxp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  ag_cmd_e       cmd,
    input  logic [AW-1:0] tgt,
    input  logic          room,
    input  logic          granted,
    output logic          want,
    output logic [AW-1:0] pc
);
    logic          halt_q;
    logic [AW-1:0] pc_q;

    always_comb begin
        want = !halt_q && (cmd == CMD_RUN) && room;
        pc   = pc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q <= 1'b1;
            pc_q   <= '0;
        end else begin
            unique case (cmd)
                CMD_JUMP: begin
                    pc_q   <= tgt + STEP;
                    halt_q <= 1'b0;
                end
                CMD_HALT: halt_q <= 1'b1;
                CMD_HOLD: pc_q   <= pc_q;
                default: begin
                    if (granted) pc_q <= pc_q + STEP;
                end
            endcase
        end
    end
endmodule

// File: rtl/fxp_fetch_pipe.sv
`timescale 1ns/1ps
module fxp_fetch_pipe
    import fxp_pkg::*;
#(
    parameter int unsigned NS = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   flush,
    input  logic   in_v,
    input  islot_t in_slot,
    input  logic   take,
    output logic   room,
    output logic   out_v,
    output islot_t out_slot
);
    logic [NS-1:0] v_q;
    islot_t        s_q   [NS];
    logic [NS-1:0] src_v;
    islot_t        src_s [NS];
    logic [NS:0]   acc;

    always_comb begin
        acc[NS] = take;
        for (int i = NS - 1; i >= 0; i--) begin
            acc[i] = !v_q[i] || acc[i+1];
        end
        src_v[0] = in_v;
        src_s[0] = in_slot;
        for (int i = 1; i < NS; i++) begin
            src_v[i] = v_q[i-1];
            src_s[i] = s_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            v_q <= '0;
        end else begin
            for (int i = 0; i < NS; i++) begin
                if (acc[i]) v_q[i] <= src_v[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NS; i++) begin
            if (acc[i]) s_q[i] <= src_s[i];
        end
    end

    assign room     = acc[0];
    assign out_v    = v_q[NS-1];
    assign out_slot = s_q[NS-1];
endmodule

// File: rtl/fxp_ififo.sv
`timescale 1ns/1ps
module fxp_ififo
    import fxp_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  islot_t        din,
    input  logic          pop_req,
    output logic          can_push,
    output logic          head_v,
    output islot_t        head,
    output logic [CW-1:0] level
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    islot_t        mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          wr, rd;

    always_comb begin
        can_push = (cnt_q != FULL);
        head_v   = (cnt_q != '0);
        wr       = push && can_push;
        rd       = pop_req && head_v;
        head     = mem[rp_q];
        level    = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
            if (rd) rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
            if (wr && !rd)      cnt_q <= cnt_q + 1'b1;
            else if (rd && !wr) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr && !flush) mem[wp_q] <= din;
    end
endmodule

// File: rtl/fxp_exec_pipe.sv
`timescale 1ns/1ps
module fxp_exec_pipe
    import fxp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          head_v,
    input  islot_t        head,
    input  logic          gnt,
    output logic          pop,
    output logic          xreq,
    output logic [AW-1:0] xaddr,
    output logic          ex_busy,
    output logic [LW-1:0] ex_left,
    output logic          ret_v,
    output logic [AW-1:0] ret_addr,
    output logic [DW-1:0] ret_word
);
    logic          do_v_q, ex_v_q, mpend_q;
    islot_t        do_q, ex_q;
    logic [LW-1:0] cnt_q;
    logic          ex_done, ex_acc, do_acc;

    always_comb begin
        ex_done = ex_v_q && (cnt_q == '0) && (!mpend_q || gnt);
        ex_acc  = !ex_v_q || ex_done;
        do_acc  = !do_v_q || ex_acc;
        pop     = head_v && do_acc;
        xreq    = ex_v_q && mpend_q;
        xaddr   = data_addr(ex_q.word);
        ex_busy = ex_v_q;
        ex_left = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            do_v_q  <= 1'b0;
            ex_v_q  <= 1'b0;
            mpend_q <= 1'b0;
            cnt_q   <= '0;
            ret_v   <= 1'b0;
        end else begin
            if (do_acc) do_v_q <= head_v;
            if (ex_acc) begin
                ex_v_q  <= do_v_q;
                cnt_q   <= do_v_q ? do_q.lat : '0;
                mpend_q <= do_v_q && needs_mem(do_q.word);
            end else begin
                if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                if (gnt) mpend_q <= 1'b0;
            end
            ret_v <= ex_done;
        end
    end

    always_ff @(posedge clk) begin
        if (do_acc && head_v) do_q <= head;
        if (ex_acc && do_v_q) ex_q <= do_q;
        if (ex_done) begin
            ret_addr <= ex_q.addr;
            ret_word <= ex_q.word;
        end
    end
endmodule

// File: rtl/fxp_bus_arb.sv
`timescale 1ns/1ps
module fxp_bus_arb
    import fxp_pkg::*;
(
    input  logic          xreq,
    input  logic [AW-1:0] xaddr,
    input  logic          freq,
    input  logic [AW-1:0] faddr,
    input  logic          ready,
    output logic          req,
    output logic          src,
    output logic [AW-1:0] addr,
    output logic          xgnt,
    output logic          fgnt
);
    always_comb begin
        req  = xreq || freq;
        src  = xreq ? SRC_EXEC : SRC_FETCH;
        addr = xreq ? xaddr : faddr;
        xgnt = xreq && ready;
        fgnt = freq && !xreq && ready;
    end
endmodule

// File: rtl/fetch_exec_core.sv
`timescale 1ns/1ps
module fetch_exec_core
    import fxp_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned FSTG  = 3,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cmd_i,
    input  logic [AW-1:0] tgt_i,
    output logic          mem_req_o,
    output logic          mem_src_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_ready_i,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic [LW-1:0] mem_rlat_i,
    output logic          ret_valid_o,
    output logic [AW-1:0] ret_addr_o,
    output logic [DW-1:0] ret_word_o
);
    ag_cmd_e       cmd;
    logic          flush;
    logic          room, want, fgnt, xgnt, xreq;
    logic [AW-1:0] ag_pc, xaddr;
    islot_t        fslot, ed_slot, head;
    logic          ed_v, can_push, head_v, pop;
    logic [CW-1:0] fifo_cnt;
    logic          ex_busy;
    logic [LW-1:0] ex_left;

    assign cmd   = ag_cmd_e'(cmd_i);
    assign flush = (cmd == CMD_JUMP);
    assign fslot = '{addr: ag_pc, word: mem_rdata_i, lat: mem_rlat_i};

    fxp_addr_gen u_ag (
        .clk(clk), .rst(rst), .cmd(cmd), .tgt(tgt_i),
        .room(room), .granted(fgnt), .want(want), .pc(ag_pc)
    );

    fxp_fetch_pipe #(.NS(FSTG)) u_fp (
        .clk(clk), .rst(rst), .flush(flush),
        .in_v(fgnt), .in_slot(fslot), .take(can_push),
        .room(room), .out_v(ed_v), .out_slot(ed_slot)
    );

    fxp_ififo #(.DEPTH(DEPTH)) u_q (
        .clk(clk), .rst(rst), .flush(flush),
        .push(ed_v), .din(ed_slot), .pop_req(pop),
        .can_push(can_push), .head_v(head_v), .head(head), .level(fifo_cnt)
    );

    fxp_exec_pipe u_ex (
        .clk(clk), .rst(rst), .head_v(head_v), .head(head), .gnt(xgnt),
        .pop(pop), .xreq(xreq), .xaddr(xaddr),
        .ex_busy(ex_busy), .ex_left(ex_left),
        .ret_v(ret_valid_o), .ret_addr(ret_addr_o), .ret_word(ret_word_o)
    );

    fxp_bus_arb u_arb (
        .xreq(xreq), .xaddr(xaddr), .freq(want), .faddr(ag_pc),
        .ready(mem_ready_i),
        .req(mem_req_o), .src(mem_src_o), .addr(mem_addr_o),
        .xgnt(xgnt), .fgnt(fgnt)
    );
endmodule

// File: rtl/fxp_chk.sv
`timescale 1ns/1ps
module fxp_chk
    import fxp_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    cmd_i,
    input logic [AW-1:0] tgt_i,
    input logic          mem_req_o,
    input logic          mem_src_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_ready_i,
    input logic          ret_valid_o,
    input logic [AW-1:0] ag_pc,
    input logic [CW-1:0] fifo_cnt,
    input logic          ex_busy,
    input logic [LW-1:0] ex_left,
    input logic          fgnt,
    input logic          xreq
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !mem_req_o && !ret_valid_o); // R1

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        fgnt && cmd_i == CMD_RUN |=> ag_pc == $past(mem_addr_o) + STEP); // R2

    AST_JUMP_PC: assert property (@(posedge clk) disable iff (rst)
        cmd_i == CMD_JUMP |=> ag_pc == $past(tgt_i) + STEP); // R3

    AST_HOLD_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        cmd_i == CMD_HOLD |-> !(mem_req_o && mem_src_o == SRC_FETCH)); // R4

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CW'(DEPTH)); // R7

    AST_LONG_HOLD: assert property (@(posedge clk) disable iff (rst)
        ex_busy && ex_left != '0 |=> ex_busy && !ret_valid_o); // R8

    AST_EXEC_FIRST: assert property (@(posedge clk) disable iff (rst)
        xreq |-> mem_req_o && mem_src_o == SRC_EXEC); // R9

    AST_NOT_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mem_ready_i && mem_req_o && mem_src_o == SRC_EXEC |=> mem_req_o && mem_src_o == SRC_EXEC); // R10
endmodule

bind fetch_exec_core fxp_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .tgt_i(tgt_i),
    .mem_req_o(mem_req_o), .mem_src_o(mem_src_o), .mem_addr_o(mem_addr_o),
    .mem_ready_i(mem_ready_i), .ret_valid_o(ret_valid_o),
    .ag_pc(ag_pc), .fifo_cnt(fifo_cnt), .ex_busy(ex_busy), .ex_left(ex_left),
    .fgnt(fgnt), .xreq(xreq)
);

// File: tb/sim_fetch_exec_core.sv
`timescale 1ns/1ps
module sim_fetch_exec_core;
    import fxp_pkg::*;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cmd = 2'd0;
    logic [AW-1:0] tgt = '0;
    logic          mem_req, mem_src, mem_ready = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic [LW-1:0] mem_rlat;
    logic          ret_valid;
    logic [AW-1:0] ret_addr;
    logic [DW-1:0] ret_word;

    localparam logic [AW-1:0] SLOW_A   = 16'h0404;
    localparam logic [LW-1:0] SLOW_LAT = 5'd31;
    localparam logic [AW-1:0] MACC_A   = 16'h0C08;
    localparam logic [AW-1:0] MACC_T   = 16'h0123;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int n_fetch = 0, n_ret = 0, n_xacc = 0;
    int watch_cyc = -1, xacc_cyc = -1;
    logic [AW-1:0] exp_fa = '0, watch_a = '0, xacc_addr = '0;
    logic [AW-1:0] ret_addr_log [512];
    int            ret_cyc_log  [512];
    bit finished = 0;

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] model_word(input logic [AW-1:0] a);
        if (a == MACC_A) return {1'b1, MACC_T[DW-2:0]};
        return {1'b0, a[DW-2:0]};
    endfunction

    assign mem_rdata = model_word(mem_addr);
    assign mem_rlat  = (mem_addr == SLOW_A) ? SLOW_LAT : '0;

    fetch_exec_core u0 (
        .clk(clk), .rst(rst), .cmd_i(cmd), .tgt_i(tgt),
        .mem_req_o(mem_req), .mem_src_o(mem_src), .mem_addr_o(mem_addr),
        .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata), .mem_rlat_i(mem_rlat),
        .ret_valid_o(ret_valid), .ret_addr_o(ret_addr), .ret_word_o(ret_word)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Bus and retirement monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req && mem_ready && mem_src == SRC_FETCH) begin
                n_fetch++;
                chk(mem_addr == exp_fa, "R2 fetch address sequence", mem_addr, exp_fa);
                exp_fa = exp_fa + 16'd4;
                if (mem_addr == watch_a) watch_cyc = cyc;
            end
            if (mem_req && mem_ready && mem_src == SRC_EXEC) begin
                n_xacc++;
                xacc_addr = mem_addr;
                xacc_cyc  = cyc;
            end
            if (ret_valid) begin
                if (n_ret < 512) begin
                    ret_addr_log[n_ret] = ret_addr;
                    ret_cyc_log[n_ret]  = cyc;
                end
                n_ret++;
                chk(ret_word == model_word(ret_addr), "R11 retired word", ret_word, model_word(ret_addr));
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_jump(input logic [AW-1:0] t, input logic [AW-1:0] w);
        @(posedge clk); #1;
        cmd = CMD_JUMP; tgt = t; exp_fa = t + 16'd4; watch_a = w;
        @(posedge clk); #1;
        cmd = CMD_RUN;
    endtask

    task automatic do_halt();
        @(posedge clk); #1;
        cmd = CMD_HALT;
        @(posedge clk); #1;
        cmd = CMD_RUN;
    endtask

    task automatic t_reset();
        step(3);
        @(negedge clk);
        chk(!mem_req && !ret_valid, "R1 quiet in reset", {mem_req, ret_valid}, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!mem_req && !ret_valid, "R1 halted after reset", {mem_req, ret_valid}, 0);
        end
    endtask

    task automatic t_stream();
        int nf0, nr0, nf1;
        nf0 = n_fetch; nr0 = n_ret;
        do_jump(16'h0100, 16'h0104);
        step(20);
        chk(ret_addr_log[nr0] == 16'h0104, "R3 first retire is target+4", ret_addr_log[nr0], 16'h0104);
        chk(ret_cyc_log[nr0] - watch_cyc == 7, "R6 fetch to retire latency", ret_cyc_log[nr0] - watch_cyc, 7);
        chk(ret_addr_log[nr0+1] == 16'h0108, "R11 retire order", ret_addr_log[nr0+1], 16'h0108);
        chk(ret_cyc_log[nr0+1] == ret_cyc_log[nr0] + 1, "R8 tag 0 one per cycle",
            ret_cyc_log[nr0+1] - ret_cyc_log[nr0], 1);
        do_halt();
        step(30);
        chk(n_fetch - nf0 == n_ret - nr0, "R5 all fetched retire", n_ret - nr0, n_fetch - nf0);
        nf1 = n_fetch;
        step(10);
        @(negedge clk);
        chk(n_fetch == nf1, "R5 no fetch after halt", n_fetch, nf1);
        chk(!ret_valid, "R5 no retire when drained", ret_valid, 0);
    endtask

    task automatic t_hold();
        int nf;
        do_jump(16'h0200, 16'h0204);
        step(6);
        cmd = CMD_HOLD;
        nf = n_fetch;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!(mem_req && mem_src == SRC_FETCH), "R4 no fetch request in hold", mem_req, 0);
        end
        @(posedge clk); #1;
        chk(n_fetch == nf, "R4 no fetch accepted in hold", n_fetch, nf);
        cmd = CMD_RUN;
        step(3);
        chk(n_fetch > nf, "R4 fetch resumes after hold", n_fetch, nf + 1);
        do_halt();
        step(30);
    endtask

    task automatic t_fill();
        int nf0, nr0;
        nf0 = n_fetch; nr0 = n_ret;
        do_jump(16'h0400, SLOW_A);
        step(28);
        chk(n_fetch - nf0 == 13, "R7 in-flight limit with full queue", n_fetch - nf0, 13);
        chk(n_ret == nr0, "R8 long instruction still executing", n_ret - nr0, 0);
        do_jump(16'h0800, 16'hFFFF);
        step(40);
        do_halt();
        step(30);
        chk(ret_addr_log[nr0]   == 16'h0404, "R3 execute survives jump", ret_addr_log[nr0], 16'h0404);
        chk(ret_addr_log[nr0+1] == 16'h0408, "R3 decode survives jump", ret_addr_log[nr0+1], 16'h0408);
        chk(ret_addr_log[nr0+2] == 16'h0804, "R3 queue flushed", ret_addr_log[nr0+2], 16'h0804);
        chk(ret_addr_log[nr0+3] == 16'h0808, "R11 order after jump", ret_addr_log[nr0+3], 16'h0808);
        chk(ret_cyc_log[nr0] - watch_cyc == 38, "R8 tag 31 gives 32 execute cycles",
            ret_cyc_log[nr0] - watch_cyc, 38);
        chk(n_ret - nr0 == n_fetch - nf0 - 11, "R3 eleven flushed", n_ret - nr0, n_fetch - nf0 - 11);
    endtask

    task automatic t_memacc();
        int nx0, nr0, nf;
        nx0 = n_xacc; nr0 = n_ret;
        do_jump(16'h0C00, MACC_A);
        step(25);
        chk(n_xacc - nx0 == 1, "R9 one data access", n_xacc - nx0, 1);
        chk(xacc_addr == MACC_T, "R9 data address", xacc_addr, MACC_T);
        chk(xacc_cyc - watch_cyc == 6, "R9 execute wins bus in first cycle", xacc_cyc - watch_cyc, 6);
        chk(ret_addr_log[nr0+1] == MACC_A, "R11 data instruction in order", ret_addr_log[nr0+1], MACC_A);
        chk(ret_cyc_log[nr0+1] - watch_cyc == 7, "R9 granted access adds no cycle",
            ret_cyc_log[nr0+1] - watch_cyc, 7);
        mem_ready = 1'b0;
        nf = n_fetch;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(mem_req, "R10 request held while not ready", mem_req, 1);
        end
        @(posedge clk); #1;
        chk(n_fetch == nf, "R10 nothing accepted while not ready", n_fetch, nf);
        mem_ready = 1'b1;
        step(4);
        chk(n_fetch > nf, "R10 fetch continues after ready", n_fetch, nf + 1);
        do_halt();
        step(30);
    endtask

    initial begin
        t_reset();
        t_stream();
        t_hold();
        t_fill();
        t_memacc();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end
endmodule